// File: doc/BRIEF.md
# Bus-Attached Multiply and Divide Unit

This block sits on a 16-bit word-addressed memory bus and offloads integer multiplication and division from a processor. Software writes two 16-bit operands into one of six operand pairs. The address of the pair alone selects the operation: one of four multiply variants with different operand signedness, or a signed or unsigned divide. On every operand write the unit recomputes the result from the pair's current contents, using the new value and the partner value already stored. It latches a 32-bit result into two result words at the same clock edge.

Results are read from two fixed offsets. For a multiply they hold the low and high halves of the product. For a divide they hold the quotient and the remainder. The result is ready for the first read that follows the write, and it stays unchanged until the next operand write. Division by zero gives a defined, non-hanging result.

Top module: `muldiv_mmio`

## Requirements
- R1: Operand pairs sit at word offsets {0,1}, {2,3}, {4,5}, {6,7}, {8,9} and {10,11}, with the even offset holding the first operand (dividend for a divide) and the odd offset the second (divisor). The low result word (product bits 15:0 or quotient) is read at offset 14 and the high word (product bits 31:16 or remainder) at offset 15.
- R2: Pair {0,1} multiplies signed by signed; 0x1234 times 0xABCD gives high 0xFA03, low 0x4FA4 whichever operand is written first.
- R3: Pair {2,3} treats the first operand as signed and the second as unsigned; pair {4,5} treats the first as unsigned and the second as signed (0x1234 signed times 0xABCD unsigned is 0x0C37_4FA4; 0xABCD signed times 0x1234 unsigned is 0xFA03_4FA4).
- R4: Pair {6,7} multiplies unsigned by unsigned (0x1234 times 0xABCD is 0x0C37_4FA4).
- R5: Pair {8,9} divides signed, truncating the quotient toward zero and giving the remainder the dividend's sign (0xABCD / 0x1234: quotient 0xFFFC, remainder 0xF49D; 0x1234 / 0xABCD: quotient 0, remainder 0x1234).
- R6: Pair {10,11} divides unsigned (0xABCD / 0x1234: quotient 9, remainder 0x07F9).
- R7: A zero divisor in either divide pair yields quotient 0xFFFF and remainder equal to the dividend.
- R8: Every operand write recomputes the result from that pair's stored partner operand and the new value. The result is returned by the first read issued after the write.
- R9: Result words hold their value until an operand write. Writes to offsets 12 to 15 change nothing.
- R10: A read strobe returns its data on the cycle after the strobe. Reads of offsets 0 to 13 return zero.
- R11: Synchronous active-low reset clears all operand and result words to zero.
- R12: Signed 0x8000 / 0xFFFF gives quotient 0x8000 and remainder 0 (wrap, no fault).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Word offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid the cycle after the strobe |

## Verification
The bench goes after the signedness corners: 0xABCD sits in different signedness slots, and the pair mix-up shows at once as 0xFA03 against 0x0C37 in the high word. Swapped pairs {2,3} and {4,5}, or a divider that floors instead of truncating, give the wrong high word or a remainder with the wrong sign. Zero divisors and the 0x8000 / 0xFFFF overflow are driven directly, because a careless divider returns X or a sign-flipped quotient there. Writes to the result offsets and reads of operand offsets are followed by result reads, to catch a design that lets those accesses clobber state. A stream of pseudo-random operands across all pairs catches a result computed from a stale partner operand.

// File: rtl/muldiv_pkg.sv
// Package: shared constants and operation encoding for the bus multiply/divide unit.
// Assumes word offsets as listed in the brief; operand pairs occupy offsets 0..11.
package muldiv_pkg;

    typedef enum logic [2:0] {
        OP_MUL_SS = 3'd0,
        OP_MUL_SU = 3'd1,
        OP_MUL_US = 3'd2,
        OP_MUL_UU = 3'd3,
        OP_DIV_S  = 3'd4,
        OP_DIV_U  = 3'd5,
        OP_NONE   = 3'd7
    } md_op_e;

    localparam int unsigned NUM_PAIRS  = 6;
    localparam int unsigned NUM_OPND   = 2 * NUM_PAIRS;
    localparam int unsigned RES_LO_OFS = 14;
    localparam int unsigned RES_HI_OFS = 15;

endpackage

// File: rtl/muldiv_decode.sv
// Module: address decoder. Maps a word offset to the operation of its pair and
// flags operand and result offsets. Assumes the offset layout in muldiv_pkg.
module muldiv_decode
    import muldiv_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output md_op_e            op,
    output logic              is_opnd,
    output logic              is_res_lo,
    output logic              is_res_hi
);

    // Purpose: classify the offset and pick the pair's operation.
    always_comb begin
        is_opnd   = (32'(addr) < NUM_OPND);
        is_res_lo = (32'(addr) == RES_LO_OFS);
        is_res_hi = (32'(addr) == RES_HI_OFS);
        case (32'(addr) >> 1)
            32'd0:   op = OP_MUL_SS;
            32'd1:   op = OP_MUL_SU;
            32'd2:   op = OP_MUL_US;
            32'd3:   op = OP_MUL_UU;
            32'd4:   op = OP_DIV_S;
            32'd5:   op = OP_DIV_U;
            default: op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/muldiv_mul.sv
// Module: combinational W x W multiplier with per-operand signedness.
// Assumes the caller registers the 2W-bit product.
module muldiv_mul #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           a_signed,
    input  logic           b_signed,
    output logic [2*W-1:0] prod
);

    logic signed [W:0]     a_x;
    logic signed [W:0]     b_x;
    logic signed [2*W-1:0] prod_s;

    // Purpose: extend each operand by one bit as its signedness demands, then multiply.
    always_comb begin
        a_x    = $signed({a_signed & a[W-1], a});
        b_x    = $signed({b_signed & b[W-1], b});
        prod_s = a_x * b_x;
        prod   = prod_s;
    end

endmodule

// File: rtl/muldiv_div.sv
// Module: combinational W / W divider, signed or unsigned. The signed mode truncates
// toward zero and gives the remainder the dividend's sign. A zero divisor gives
// an all-ones quotient and the dividend as remainder. Assumes the caller registers the outputs.
module muldiv_div #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         is_signed,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);

    logic         neg_n;
    logic         neg_d;
    logic [W-1:0] mag_n;
    logic [W-1:0] mag_d;
    logic [W-1:0] uq;
    logic [W-1:0] ur;

    // Purpose: divide magnitudes, then restore signs; guard the zero divisor.
    always_comb begin
        neg_n = is_signed & dividend[W-1];
        neg_d = is_signed & divisor[W-1];
        mag_n = neg_n ? (~dividend + 1'b1) : dividend;
        mag_d = neg_d ? (~divisor + 1'b1) : divisor;
        uq    = '0;
        ur    = '0;
        if (divisor == '0) begin
            quot = '1;
            rem  = dividend;
        end else begin
            uq   = mag_n / mag_d;
            ur   = mag_n % mag_d;
            quot = (neg_n ^ neg_d) ? (~uq + 1'b1) : uq;
            rem  = neg_n ? (~ur + 1'b1) : ur;
        end
    end

endmodule

// File: rtl/muldiv_mmio.sv
// Module: top of the bus multiply/divide unit. Holds twelve operand words and two
// result words. An operand write stores the value and latches the pair's result at
// the same edge. Reads are registered. Assumes the bus issues at most one of
// read or write per cycle.
module muldiv_mmio
    import muldiv_pkg::*;
#(
    parameter int unsigned W      = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    input  logic              bus_rd,
    output logic [W-1:0]      bus_rdata
);

    localparam logic [ADDR_W-1:0] UDIV_DIVISOR_OFS = ADDR_W'(NUM_OPND - 1);
    localparam logic [ADDR_W-1:0] SDIV_DIVISOR_OFS = ADDR_W'(NUM_OPND - 3);

    md_op_e            op;
    logic              is_opnd;
    logic              is_res_lo;
    logic              is_res_hi;
    logic [W-1:0]      opnd_q [NUM_OPND];
    logic [ADDR_W-1:0] idx_first;
    logic [ADDR_W-1:0] idx_second;
    logic [W-1:0]      op_a;
    logic [W-1:0]      op_b;
    logic [2*W-1:0]    prod;
    logic [W-1:0]      quot;
    logic [W-1:0]      rem;
    logic [W-1:0]      res_lo_q;
    logic [W-1:0]      res_hi_q;
    logic              opnd_we;

    muldiv_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (bus_addr),
        .op        (op),
        .is_opnd   (is_opnd),
        .is_res_lo (is_res_lo),
        .is_res_hi (is_res_hi)
    );

    assign opnd_we = bus_wr & is_opnd;

    // Operand storage: one register per offset.
    for (genvar gi = 0; gi < NUM_OPND; gi++) begin : g_opnd
        // Purpose: store an operand word when its own offset is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                opnd_q[gi] <= '0;
            else if (opnd_we && (bus_addr == ADDR_W'(gi)))
                opnd_q[gi] <= bus_wdata;
        end
    end

    // Purpose: form the pair's operands from the new write and the stored partner.
    always_comb begin
        idx_first  = {bus_addr[ADDR_W-1:1], 1'b0};
        idx_second = {bus_addr[ADDR_W-1:1], 1'b1};
        op_a = '0;
        op_b = '0;
        if (is_opnd) begin
            op_a = bus_addr[0] ? opnd_q[idx_first] : bus_wdata;
            op_b = bus_addr[0] ? bus_wdata : opnd_q[idx_second];
        end
    end

    muldiv_mul #(.W(W)) u_mul (
        .a        (op_a),
        .b        (op_b),
        .a_signed ((op == OP_MUL_SS) || (op == OP_MUL_SU)),
        .b_signed ((op == OP_MUL_SS) || (op == OP_MUL_US)),
        .prod     (prod)
    );

    muldiv_div #(.W(W)) u_div (
        .dividend  (op_a),
        .divisor   (op_b),
        .is_signed (op == OP_DIV_S),
        .quot      (quot),
        .rem       (rem)
    );

    // Purpose: latch the result of the written pair at the operand-write edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo_q <= '0;
            res_hi_q <= '0;
        end else if (opnd_we) begin
            if ((op == OP_DIV_S) || (op == OP_DIV_U)) begin
                res_lo_q <= quot;
                res_hi_q <= rem;
            end else begin
                res_lo_q <= prod[W-1:0];
                res_hi_q <= prod[2*W-1:W];
            end
        end
    end

    // Purpose: registered read port; only the result offsets return data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= is_res_lo ? res_lo_q : (is_res_hi ? res_hi_q : '0);
    end

    // R9: results are stable unless an operand offset is written.
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && is_opnd) |=> $stable({res_hi_q, res_lo_q}));

    // R10: a read of a non-result offset returns zero on the next cycle.
    assert_opnd_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && (32'(bus_addr) < RES_LO_OFS)) |=> (bus_rdata == '0));

    // R7: a zero divisor written to the signed divide pair gives an all-ones quotient.
    assert_div_zero_quot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == SDIV_DIVISOR_OFS) && (bus_wdata == '0)) |=> (res_lo_q == '1));

    // R6: an unsigned divide by a nonzero divisor leaves a remainder below the divisor.
    assert_udiv_rem_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == UDIV_DIVISOR_OFS) && (bus_wdata != '0)) |=> (res_hi_q < $past(bus_wdata)));

endmodule

// File: tb/muldiv_mmio_tb.sv
`timescale 1ns/1ps
module muldiv_mmio_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    muldiv_mmio dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata)
    );

    task automatic put_summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Reference model written from the requirements: returns {high word, low word}.
    function automatic logic [31:0] model(int pair, logic [15:0] a, logic [15:0] b);
        longint x;
        longint y;
        longint p;
        longint q;
        longint r;
        bit sa = (pair == 0) || (pair == 1) || (pair == 4);
        bit sb = (pair == 0) || (pair == 2) || (pair == 4);
        x = sa ? longint'($signed(a)) : longint'(a);
        y = sb ? longint'($signed(b)) : longint'(b);
        if (pair < 4) begin
            p = x * y;
            return p[31:0];
        end
        if (b == 16'h0) return {a, 16'hFFFF};
        q = x / y;
        r = x % y;
        return {r[15:0], q[15:0]};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run_pair(input logic [3:0] base, input logic [15:0] a, input logic [15:0] b,
                            input logic [15:0] e_lo, input logic [15:0] e_hi, input string tag);
        wr(base, a);
        wr(base + 4'd1, b);
        rd(4'd14, e_lo, tag);
        rd(4'd15, e_hi, tag);
    endtask

    // Monitor: on each read strobe, compare the next-cycle data with the queue head.
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (exp_q.size() != 0) begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    n_cmp++;
                    if (bus_rdata !== e) begin
                        n_bad++;
                        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        put_summary();
    end

    initial begin
        logic [31:0] seed;
        logic [31:0] m;
        seed = 32'h1F2E_3D4C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state of results and operands.
        rd(4'd14, 16'h0000, "R11 low after reset");
        rd(4'd15, 16'h0000, "R11 high after reset");
        wr(4'd1, 16'h0005);
        rd(4'd14, 16'h0000, "R11 first operand cleared");

        // R2 and R1: signed x signed, both write orders.
        run_pair(4'd0, 16'h1234, 16'hABCD, 16'h4FA4, 16'hFA03, "R2 ss");
        wr(4'd1, 16'h1234);
        wr(4'd0, 16'hABCD);
        rd(4'd14, 16'h4FA4, "R1 low word offset");
        rd(4'd15, 16'hFA03, "R2 ss reversed order");

        // R3: mixed signedness pairs.
        run_pair(4'd2, 16'h1234, 16'hABCD, 16'h4FA4, 16'h0C37, "R3 s*u");
        run_pair(4'd2, 16'hABCD, 16'h1234, 16'h4FA4, 16'hFA03, "R3 s*u neg");
        run_pair(4'd4, 16'h1234, 16'hABCD, 16'h4FA4, 16'hFA03, "R3 u*s");
        run_pair(4'd4, 16'hABCD, 16'h1234, 16'h4FA4, 16'h0C37, "R3 u*s big");

        // R4: unsigned x unsigned.
        run_pair(4'd6, 16'hABCD, 16'h1234, 16'h4FA4, 16'h0C37, "R4 uu");

        // R8: recompute with the stored partner (6 <- 2, partner 7 = 0x1234).
        wr(4'd6, 16'h0002);
        rd(4'd14, 16'h2468, "R8 partner reuse low");
        rd(4'd15, 16'h0000, "R8 partner reuse high");

        // R5: signed divide.
        run_pair(4'd8, 16'hABCD, 16'h1234, 16'hFFFC, 16'hF49D, "R5 neg/pos");
        run_pair(4'd8, 16'h1234, 16'hABCD, 16'h0000, 16'h1234, "R5 small/large");
        run_pair(4'd8, 16'h0007, 16'hFFFE, 16'hFFFD, 16'h0001, "R5 pos/neg");
        run_pair(4'd8, 16'hFFF9, 16'h0002, 16'hFFFD, 16'hFFFF, "R5 rem sign");

        // R12: overflow case.
        run_pair(4'd8, 16'h8000, 16'hFFFF, 16'h8000, 16'h0000, "R12 overflow");

        // R6: unsigned divide.
        run_pair(4'd10, 16'hABCD, 16'h1234, 16'h0009, 16'h07F9, "R6 udiv");

        // R7: divide by zero in both pairs.
        run_pair(4'd8, 16'hFFF9, 16'h0000, 16'hFFFF, 16'hFFF9, "R7 sdiv by zero");
        run_pair(4'd10, 16'h1234, 16'h0000, 16'hFFFF, 16'h1234, "R7 udiv by zero");

        // R9: writes to result offsets are ignored; results hold across reads.
        wr(4'd14, 16'h5555);
        wr(4'd15, 16'hAAAA);
        wr(4'd12, 16'h7777);
        rd(4'd14, 16'hFFFF, "R9 result low held");
        rd(4'd15, 16'h1234, "R9 result high held");

        // R10: non-result offsets read as zero.
        rd(4'd0, 16'h0000, "R10 operand offset 0");
        rd(4'd9, 16'h0000, "R10 operand offset 9");
        rd(4'd13, 16'h0000, "R10 offset 13");
        rd(4'd14, 16'hFFFF, "R10 result after zero reads");

        // R8: pseudo-random operands across all pairs.
        for (int i = 0; i < 60; i++) begin
            int p;
            logic [15:0] a;
            logic [15:0] b;
            seed = seed * 32'd1103515245 + 32'd12345;
            p = int'(seed[30:28]) % 6;
            a = seed[15:0];
            seed = seed * 32'd1103515245 + 32'd12345;
            b = (seed[4:0] == 5'd0) ? 16'h0000 : seed[27:12];
            m = model(p, a, b);
            run_pair(4'(2 * p), a, b, m[15:0], m[31:16], "R8 random");
        end

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R10: got %0d pending reads expected 0", exp_q.size());
        end
        put_summary();
    end

endmodule